// File: doc/BRIEF.md
# Prescaled One-Shot Countdown Timer

This block is a one-shot countdown timer of configurable width (32 bits by default) with a power-of-two clock prescaler. Software reaches it through a small synchronous word-addressed register port. One register selects the prescale ratio, a second takes the start value, and a third reports how much of the countdown is left.

Writing a non-zero start value loads the counter and restarts the prescaler from phase zero. The counter then steps down once per prescaled tick. When it steps from one to zero, the block raises a one-clock expiry pulse and stops. Writing zero cancels any countdown in progress.

The prescale selector is a 3-bit value assembled from two separated pieces of the configuration word. It is then mapped with a rotate-by-one rule, so the largest selector gives the fastest rate.

Top module: `prescaled_countdown`

## Requirements
- R1: The selector is f = {cfg[3], cfg[1:0]}. Each step of the counter takes 2^((f+1) mod 8) clocks: f=0 gives 2, f=6 gives 128 and f=7 gives 1.
- R2: The configuration register sits at word offset 0 and keeps only bits 3, 1 and 0 of a write (mask 0xB). Every other bit reads back as zero.
- R3: A write to word offset 1 stores the full-width start value, which reads back at offset 1. A non-zero value loads the counter, restarts it even if a countdown is already running, and clears the prescaler phase. With ratio N, the first step happens N clocks after the write edge.
- R4: The remaining-count register at word offset 2 is read-only. A write to it changes neither the countdown nor its read value.
- R5: A read of offset 2 returns 0 while the timer is stopped. While it runs, the read returns the number of prescaled ticks still to go, rounded up, which is start − floor(m/N) m clocks after the load.
- R6: Exactly start×N clocks after the load edge, expire_o is high for one cycle. After that the counter rests at zero until the next load.
- R7: Writing a start value of 0 stops the timer, including one that is running. No expiry pulse follows, and offset 2 reads 0.
- R8: Read data appears one clock after the offset is presented. Offsets 3 to 15 read 0, and writes to them are ignored.
- R9: After reset, expire_o and the read data are 0, the timer is stopped, and the configuration register is 0, which selects a ratio of 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe for the addressed register |
| bus_off_i | input | OFF_W (4) | Word offset of the register |
| bus_wdata_i | input | CNT_W (32) | Write data |
| bus_rdata_o | output | CNT_W (32) | Registered read data, one cycle after the offset |
| expire_o | output | 1 | One-cycle pulse when the count reaches zero |

## Verification
The bench builds the block with its defaults: a 32-bit counter and a 4-bit word offset. With these values, every one of the eight prescale selectors can be swept with start values 1 to 3. The bench checks the read value on every clock and requires the expiry pulse to land on exactly one clock, both computed from start×N. The full counter width is exercised by a load near the top of the 32-bit range. The remaining cases are covered separately: restart during a running countdown, a zero load during a running countdown, writes to the read-only and unmapped offsets, and the masking of the configuration register.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
    localparam int CFG_W   = 4;
    localparam int SHIFT_W = 3;
    localparam logic [CFG_W-1:0] CFG_KEEP = 4'hB;
    localparam int OFF_CFG  = 0;
    localparam int OFF_INIT = 1;
    localparam int OFF_CUR  = 2;
endpackage

// File: rtl/cdt_divdec.sv
// Turns the configuration word into a prescale shift amount.
module cdt_divdec
    import cdt_pkg::*;
(
    input  logic [CFG_W-1:0]   cfg_i,
    output logic [SHIFT_W-1:0] shift_o
);
    logic [SHIFT_W-1:0] sel;

    always_comb begin
        sel     = {cfg_i[3], cfg_i[1:0]};
        // Adding one inside SHIFT_W bits wraps 7 back to 0 (divide by 1).
        shift_o = sel + SHIFT_W'(1);
    end
endmodule

// File: rtl/cdt_prescale.sv
// Phase counter that produces a tick every 2^shift clocks while running.
module cdt_prescale #(
    parameter int SHIFT_W = 3
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               run_i,
    input  logic               restart_i,
    input  logic [SHIFT_W-1:0] shift_i,
    output logic               tick_o
);
    localparam int PH_W = (1 << SHIFT_W) - 1;

    typedef struct packed {
        logic [PH_W-1:0] phase;
    } ps_t;

    ps_t             ps_d, ps_q;
    logic [PH_W:0]   span;
    logic [PH_W:0]   span_m1;
    logic [PH_W-1:0] mask;

    always_comb begin
        span    = (PH_W+1)'(1) << shift_i;
        span_m1 = span - (PH_W+1)'(1);
        mask    = span_m1[PH_W-1:0];
        tick_o  = run_i && !restart_i && ((ps_q.phase & mask) == mask);
        ps_d    = ps_q;
        if (restart_i || !run_i) begin
            ps_d.phase = '0;
        end else begin
            ps_d.phase = ps_q.phase + PH_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ps_q <= '0;
        else         ps_q <= ps_d;
    end

    // R1: with a constant ratio above one, ticks never fall on adjacent clocks
    a_r1_no_adjacent_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_o && shift_i != '0) |=> (!tick_o || !$stable(shift_i)));
endmodule

// File: rtl/cdt_counter.sv
// Down counter with load, stop-at-zero and a one-cycle expiry flag.
module cdt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] count_o,
    output logic             active_o,
    output logic             expire_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
        logic             expire;
    } cnt_t;

    cnt_t cs_d, cs_q;

    always_comb begin
        cs_d        = cs_q;
        cs_d.expire = 1'b0;
        if (load_i) begin
            cs_d.cnt = load_val_i;
            cs_d.run = (load_val_i != '0);
        end else if (cs_q.run && tick_i) begin
            cs_d.cnt = cs_q.cnt - CNT_W'(1);
            if (cs_q.cnt == CNT_W'(1)) begin
                cs_d.run    = 1'b0;
                cs_d.expire = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cs_q <= '0;
        else         cs_q <= cs_d;
    end

    assign count_o  = cs_q.cnt;
    assign active_o = cs_q.run;
    assign expire_o = cs_q.expire;

    // R6: the expiry flag lasts one clock
    a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire_o |=> !expire_o);
    // R6: expiry leaves the counter stopped at zero
    a_r6_rest_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire_o |-> (count_o == '0 && !active_o));
    // R3: a load takes the whole value
    a_r3_load_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> count_o == $past(load_val_i));
    // R7: a zero load stops without a pulse
    a_r7_zero_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && load_val_i == '0) |=> (!active_o && !expire_o));
    // R5: without a load the count never rises
    a_r5_no_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> count_o <= $past(count_o));
endmodule

// File: rtl/prescaled_countdown.sv
module prescaled_countdown
    import cdt_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int OFF_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             bus_we_i,
    input  logic [OFF_W-1:0] bus_off_i,
    input  logic [CNT_W-1:0] bus_wdata_i,
    output logic [CNT_W-1:0] bus_rdata_o,
    output logic             expire_o
);
    localparam logic [OFF_W-1:0] A_CFG  = OFF_W'(OFF_CFG);
    localparam logic [OFF_W-1:0] A_INIT = OFF_W'(OFF_INIT);
    localparam logic [OFF_W-1:0] A_CUR  = OFF_W'(OFF_CUR);

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic [CNT_W-1:0] init;
        logic [CNT_W-1:0] rdata;
    } regs_t;

    regs_t              rg_d, rg_q;
    logic               load;
    logic [SHIFT_W-1:0] shift;
    logic               tick;
    logic [CNT_W-1:0]   count;
    logic               active;

    assign load = bus_we_i && (bus_off_i == A_INIT);

    cdt_divdec u_dec (
        .cfg_i   (rg_q.cfg),
        .shift_o (shift)
    );

    cdt_prescale #(.SHIFT_W(SHIFT_W)) u_pre (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (active),
        .restart_i (load),
        .shift_i   (shift),
        .tick_o    (tick)
    );

    cdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (load),
        .load_val_i (bus_wdata_i),
        .tick_i     (tick),
        .count_o    (count),
        .active_o   (active),
        .expire_o   (expire_o)
    );

    always_comb begin
        rg_d = rg_q;
        if (bus_we_i) begin
            if (bus_off_i == A_CFG)  rg_d.cfg  = bus_wdata_i[CFG_W-1:0] & CFG_KEEP;
            if (bus_off_i == A_INIT) rg_d.init = bus_wdata_i;
        end
        case (bus_off_i)
            A_CFG:   rg_d.rdata = CNT_W'(rg_q.cfg);
            A_INIT:  rg_d.rdata = rg_q.init;
            A_CUR:   rg_d.rdata = active ? count : '0;
            default: rg_d.rdata = '0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rg_q <= '0;
        else         rg_q <= rg_d;
    end

    assign bus_rdata_o = rg_q.rdata;

    // R2: configuration reads show only the kept bits
    a_r2_cfg_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(bus_off_i) == A_CFG) |-> ((bus_rdata_o & ~CNT_W'(CFG_KEEP)) == '0));
    // R8: unmapped offsets read zero
    a_r8_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(bus_off_i) > A_CUR) |-> (bus_rdata_o == '0));
endmodule

// File: tb/sim_prescaled_countdown.sv
module sim_prescaled_countdown;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [3:0]  off = 4'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        expire;
    int          errors = 0;
    int          checks = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    prescaled_countdown u0 (
        .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_off_i(off),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .expire_o(expire)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] o, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; off = o; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] o, input logic [31:0] exp, input string req);
        @(negedge clk);
        off = o;
        @(negedge clk);
        chk(rdata == exp, req, rdata, exp);
    endtask

    function automatic int div_of(input int f);
        return 1 << ((f + 1) % 8);
    endfunction

    // Load val, then on each of steps clocks compare the remaining count and the pulse.
    task automatic start_watch(input logic [31:0] val, input int dv, input int steps, input int poke);
        longint e;
        longint pulse_at;
        @(negedge clk);
        we = 1'b1; off = 4'd1; wdata = val;
        @(negedge clk);
        we = 1'b0; off = 4'd2;
        pulse_at = longint'({32'd0, val}) * dv;
        for (int n = 1; n <= steps; n++) begin
            if (n == poke) begin we = 1'b1; wdata = 32'h0; end
            @(negedge clk);
            we = 1'b0;
            e = longint'({32'd0, val}) - longint'((n - 1) / dv);
            if (e < 0) e = 0;
            chk(rdata == e[31:0], "R5 remaining count", rdata, e);
            chk(expire == (n == pulse_at), "R6 expiry timing", expire, (n == pulse_at));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state
        chk(expire == 1'b0, "R9 expire at reset", expire, 0);
        chk(rdata == 32'd0, "R9 rdata at reset", rdata, 0);
        rd_chk(4'd0, 32'd0, "R9 cfg reset");
        rd_chk(4'd2, 32'd0, "R9 stopped after reset");
        // R2 masking of the configuration word
        wr(4'd0, 32'hFFFF_FFFF);
        rd_chk(4'd0, 32'h0000_000B, "R2 cfg mask");
        wr(4'd0, 32'h0000_0004);
        rd_chk(4'd0, 32'h0, "R2 cfg bit2 dropped");
        // R1 R6: sweep all selectors with small start values
        for (int f = 0; f < 8; f++) begin
            wr(4'd0, {28'd0, f[2], 1'b0, f[1:0]});
            for (int v = 1; v <= 3; v++)
                start_watch(v, div_of(f), v * div_of(f) + 3, 0);
        end
        // R3 restart while running (ratio 1, f = 7)
        wr(4'd0, 32'h0000_000B);
        start_watch(32'd5, 1, 2, 0);
        start_watch(32'd3, 1, 6, 0);
        rd_chk(4'd1, 32'd3, "R3 start value readback");
        // R3 full width load
        start_watch(32'hFFFF_FFF0, 1, 4, 0);
        // R7 zero cancels the running countdown
        start_watch(32'd0, 1, 12, 0);
        rd_chk(4'd1, 32'd0, "R7 start value zero readback");
        // R4 write to the read-only register mid countdown (ratio 2)
        wr(4'd0, 32'h0000_0000);
        start_watch(32'd6, 2, 15, 4);
        // R7 zero load mid countdown at ratio 2
        start_watch(32'd9, 2, 5, 0);
        start_watch(32'd0, 2, 30, 0);
        // R8 unmapped offsets
        wr(4'd5, 32'hDEAD_BEEF);
        rd_chk(4'd5, 32'd0, "R8 unmapped read");
        rd_chk(4'd15, 32'd0, "R8 top offset read");
        rd_chk(4'd0, 32'd0, "R8 unmapped write left cfg");
        rd_chk(4'd1, 32'd0, "R8 unmapped write left start");
        rd_chk(4'd2, 32'd0, "R8 unmapped write left count");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule